// File: doc/BRIEF.md
# TDM Audio Frame Serializer

This block is the transmit side of a fixed-rate serial audio link that carries time-division-multiplexed frames. It runs on the incoming bit clock and cuts time into frames of 256 bit periods. Each frame starts with a 16-bit tag phase, during which the frame sync output is held high. Twelve 20-bit data slots follow, with sync low. The frame is sent one bit at a time on a single data line, most significant bit first in every field. With a 12.288 MHz bit clock, frames repeat at 48 kHz.

Upstream logic provides the tag word and all twelve slot payloads in parallel. The tag bits act as the valid flags. Bit 15 flags the frame as a whole, and bits 14 down to 3 mark slots 1 to 12. The block copies these inputs into its shift register once per frame, on the same edge that raises sync. Any slot whose tag bit is 0 is sent as all zeros. The block pulses `ready_o` right after each copy, so upstream logic knows when to present the next frame. It also pulses `frame_start_o` in the cycle the first tag bit appears on the line.

Top module: `tdm_frame_tx`

## Requirements
- R1: Sync rises once every 256 clock cycles, and a frame is exactly 256 bit periods long.
- R2: In every frame, sync is high for exactly 16 consecutive cycles, starting with the frame's first cycle, and low for the remaining 240 cycles.
- R3: Data lags sync by one cycle. In the cycle after sync rises, the line carries tag bit 15. Frame position p (0 to 255) appears p+1 cycles after sync rises, and each field is sent most significant bit first.
- R4: Frame positions 0 to 12 carry `tag_i` bits 15 down to 3. Positions 13 to 15 are always driven 0, whatever `tag_i` bits 2 to 0 hold.
- R5: Slot s (1 to 12) occupies frame positions 16+20(s-1) to 35+20(s-1). Its payload is `slot_data_i[20(s-1)+19 : 20(s-1)]`, sent from bit 19 down to bit 0.
- R6: If `tag_i` bit 15-s is 0, slot s is driven as 20 zeros, whatever its payload holds.
- R7: Inputs are sampled only on the rising edge that raises sync. Changing them at any other time does not alter the frame being sent.
- R8: `ready_o` is high for exactly one cycle per frame: the first cycle in which sync is high. `frame_start_o` is high for exactly one cycle per frame, the cycle right after that.
- R9: While `rst` is sampled high, sync, data, `ready_o` and `frame_start_o` are all low. The first rising edge after `rst` is released starts a new frame: it raises sync and samples the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tag_i | input | 16 | Tag word: bit 15 frame valid, bits 14..3 slot 1..12 valid |
| slot_data_i | input | 240 | Twelve 20-bit payloads; slot 1 in bits 19:0 |
| sync_o | output | 1 | Frame sync, high during the tag phase |
| sdata_o | output | 1 | Serial frame data |
| ready_o | output | 1 | One-cycle pulse after the inputs are sampled |
| frame_start_o | output | 1 | One-cycle pulse as the first tag bit goes out |

## Verification
The assertions assume that `clk` is the only timing reference. They also assume that reset is released on a clock boundary, so the frame counter starts from its wrap value. The padding check assumes nothing about `tag_i` bits 2 to 0, so the stimulus deliberately sets those bits to 1 in several frames. Inputs always change half a cycle away from the rising edge. They are loaded with the next frame's contents well before the sampling edge and scrambled with random values right after it. This keeps every sample clean while still testing R7.

// File: rtl/tdmx_pkg.sv
package tdmx_pkg;
  typedef enum logic {
    PH_TAG  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/tdmx_timer.sv
module tdmx_timer
  import tdmx_pkg::*;
#(
  parameter int FRAME_LEN = 256,
  parameter int TAG_W     = 16,
  localparam int CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o,
  output logic             sync_o,
  output logic             ready_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             wrap;
  phase_e           ph_nxt;
  logic             sync_q, ready_q, start_q;

  always_comb begin
    wrap    = (cnt == LAST);
    cnt_nxt = wrap ? '0 : cnt + 1'b1;
    ph_nxt  = (cnt_nxt < CNT_W'(TAG_W)) ? PH_TAG : PH_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= LAST;
      sync_q  <= 1'b0;
      ready_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      sync_q  <= (ph_nxt == PH_TAG);
      ready_q <= wrap;
      start_q <= (cnt == '0);
    end
  end

  assign cnt_o   = cnt;
  assign load_o  = wrap;
  assign sync_o  = sync_q;
  assign ready_o = ready_q;
  assign start_o = start_q;

  // R1
  sync_period_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_q) |-> ($past(cnt) == LAST) && ready_q);

  // R2
  sync_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_q) |-> (cnt == CNT_W'(TAG_W)));

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> !ready_q && start_q);

  // R8
  ready_in_sync_chk: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> sync_q);
endmodule

// File: rtl/tdmx_assembler.sv
module tdmx_assembler #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W,
  localparam int PAD_W     = TAG_W - 1 - NUM_SLOTS
) (
  input  logic [TAG_W-1:0]            tag_i,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slot_data_i,
  output logic [FRAME_LEN-1:0]        frame_o
);
  // The tag field keeps the frame flag and one flag per slot; the rest is padding.
  generate
    if (PAD_W > 0) begin : g_pad
      assign frame_o[FRAME_LEN-1 -: TAG_W] = {tag_i[TAG_W-1 -: NUM_SLOTS+1], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign frame_o[FRAME_LEN-1 -: TAG_W] = tag_i[TAG_W-1 -: TAG_W];
    end
  endgenerate

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam int TOP = FRAME_LEN - 1 - TAG_W - k * SLOT_W;
    assign frame_o[TOP -: SLOT_W] =
      tag_i[TAG_W-2-k] ? slot_data_i[k*SLOT_W +: SLOT_W] : '0;
  end
endmodule

// File: rtl/tdmx_shifter.sv
module tdmx_shifter #(
  parameter int FRAME_LEN = 256,
  parameter int TAG_W     = 16,
  parameter int NUM_SLOTS = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  output logic                 sdata_o
);
  localparam int PAD_W = TAG_W - 1 - NUM_SLOTS;

  logic [FRAME_LEN-1:0] sr;
  logic                 sdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      sdata_q <= 1'b0;
    end else begin
      sdata_q <= sr[FRAME_LEN-1];
      sr      <= load_i ? frame_i : {sr[FRAME_LEN-2:0], 1'b0};
    end
  end

  assign sdata_o = sdata_q;

  generate
    if (PAD_W > 0) begin : g_padchk
      // R4
      tag_pad_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |-> (frame_i[FRAME_LEN-TAG_W +: PAD_W] == '0));
    end
  endgenerate
endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W,
  localparam int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [TAG_W-1:0]            tag_i,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slot_data_i,
  output logic                        sync_o,
  output logic                        sdata_o,
  output logic                        ready_o,
  output logic                        frame_start_o
);
  logic [CNT_W-1:0]     cnt;
  logic                 load;
  logic [FRAME_LEN-1:0] frame;

  tdmx_timer #(.FRAME_LEN(FRAME_LEN), .TAG_W(TAG_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .cnt_o   (cnt),
    .load_o  (load),
    .sync_o  (sync_o),
    .ready_o (ready_o),
    .start_o (frame_start_o)
  );

  tdmx_assembler #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_asm (
    .tag_i       (tag_i),
    .slot_data_i (slot_data_i),
    .frame_o     (frame)
  );

  tdmx_shifter #(.FRAME_LEN(FRAME_LEN), .TAG_W(TAG_W), .NUM_SLOTS(NUM_SLOTS)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .frame_i (frame),
    .sdata_o (sdata_o)
  );

  // R3
  first_tag_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start_o && (cnt == CNT_W'(1))) |-> (sdata_o == $past(frame[FRAME_LEN-1], 2)));
endmodule

// File: tb/tdm_frame_tx_test.sv
module tdm_frame_tx_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  tag_i = '0;
  logic [239:0] slot_data_i = '0;
  logic         sync_o, sdata_o, ready_o, frame_start_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [15:0]  cur_tag;
  logic [239:0] cur_data;

  tdm_frame_tx uut (
    .clk(clk), .rst(rst), .tag_i(tag_i), .slot_data_i(slot_data_i),
    .sync_o(sync_o), .sdata_o(sdata_o), .ready_o(ready_o), .frame_start_o(frame_start_o)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [255:0] got, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Position p of the frame is returned at bit 255-p.
  function automatic logic [255:0] exp_frame(input logic [15:0] tg, input logic [239:0] d);
    logic [255:0] e = '0;
    for (int b = 0; b < 13; b++) e[255-b] = tg[15-b];
    for (int s = 1; s <= 12; s++)
      if (tg[15-s])
        for (int i = 0; i < 20; i++) e[255-16-(s-1)*20-i] = d[(s-1)*20+19-i];
    return e;
  endfunction

  function automatic logic [239:0] rand_data();
    logic [239:0] r = '0;
    for (int w = 0; w < 8; w++) r[w*30 +: 30] = 30'($urandom);
    return r;
  endfunction

  // Called at the falling edge in the cycle sync first reads high (j=0).
  task automatic run_frame(input logic [15:0] nt, input logic [239:0] nd);
    logic [255:0] got = '0, sync_got = '0, exp, sync_exp;
    int ready_hits = 0, start_hits = 0;
    bit start_ok = 1'b0, ready_last = 1'b0;
    exp = exp_frame(cur_tag, cur_data);
    sync_exp = {{16{1'b1}}, {240{1'b0}}};
    sync_got[255] = sync_o;
    for (int j = 1; j <= 256; j++) begin
      @(negedge clk);
      got[256-j] = sdata_o;
      if (j < 256) sync_got[255-j] = sync_o;
      if (ready_o) ready_hits++;
      if (frame_start_o) begin start_hits++; if (j == 1) start_ok = 1'b1; end
      if (j == 256) ready_last = ready_o;
      if (j == 256) check(sync_o == 1'b1, "R1 sync period", 256'(sync_o), 256'(1));
      if (j == 3) begin
        tag_i = 16'($urandom);
        slot_data_i = rand_data();
      end
      if (j == 200) begin
        tag_i = nt;
        slot_data_i = nd;
      end
    end
    check(sync_got == sync_exp, "R2 sync pattern", sync_got, sync_exp);
    check(got == exp, "R3/R5/R7 frame bits", got, exp);
    check(got[242:240] == 3'b000, "R4 tag padding", 256'(got[242:240]), 256'(0));
    for (int s = 1; s <= 12; s++)
      if (!cur_tag[15-s])
        check(got[255-16-(s-1)*20 -: 20] == '0, "R6 invalid slot zero",
              256'(got[255-16-(s-1)*20 -: 20]), 256'(0));
    check(ready_hits == 1 && ready_last, "R8 ready pulse", 256'(ready_hits), 256'(1));
    check(start_hits == 1 && start_ok, "R8 frame start pulse", 256'(start_hits), 256'(1));
    cur_tag = nt;
    cur_data = nd;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0]  t;
    logic [239:0] d;
    void'($urandom(32'd1234));
    // Reset state, R9
    tag_i = 16'hFFFF;
    slot_data_i = {240{1'b1}};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check({sync_o, sdata_o, ready_o, frame_start_o} == 4'b0, "R9 reset outputs low",
            256'({sync_o, sdata_o, ready_o, frame_start_o}), 256'(0));
    end
    rst = 1'b0;
    @(negedge clk);
    check(sync_o && ready_o && !sdata_o, "R9 first frame after release",
          256'({sync_o, ready_o, sdata_o}), 256'(3'b110));
    cur_tag = 16'hFFFF;
    cur_data = {240{1'b1}};
    // Directed frames: all-invalid with ones, alternating, frame flag clear
    run_frame(16'h0007, {240{1'b1}});
    run_frame(16'hAAAA, {12{20'hA5C3F}});
    run_frame(16'h5555, {12{20'h80001}});
    run_frame(16'h7FF8, rand_data());
    for (int f = 0; f < 6; f++) begin
      t = 16'($urandom);
      d = rand_data();
      run_frame(t, d);
    end
    // Reset in the middle of a frame, R9
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check({sync_o, sdata_o, ready_o, frame_start_o} == 4'b0, "R9 mid-frame reset",
          256'({sync_o, sdata_o, ready_o, frame_start_o}), 256'(0));
    @(negedge clk);
    t = 16'hC00F;
    d = rand_data();
    tag_i = t;
    slot_data_i = d;
    rst = 1'b0;
    @(negedge clk);
    check(sync_o && ready_o, "R9 restart after reset", 256'({sync_o, ready_o}), 256'(2'b11));
    cur_tag = t;
    cur_data = d;
    run_frame(16'hFFF8, rand_data());
    run_frame(16'h8000, rand_data());
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule